// File: doc/BRIEF.md
# Burst DMA Bus Master

This block is a DMA engine that masters a local add-on bus on behalf of a bridge chip's two FIFOs. Software writes a start address and a byte count. After that, the status flag of the selected FIFO acts as the transfer request. The engine asks for the bus with a hold request and waits for the hold acknowledge. It then runs cycles in the format of a burst-capable embedded processor bus. Each cycle has a one-cycle address phase, one to four data phases and a recovery phase.

A FIFO can supply or accept data without limit, but the emulated bus accepts at most four data phases per address phase. The engine therefore splits a long transfer into bursts of at most four beats. Each new burst gets a fresh address phase at the continued address. After each burst, the recovery phase decides what happens next. The engine waits there while the target still signals ready. It starts a new address phase if the request is still present and the count is nonzero. Otherwise it releases the bus.

Top module: `burst_dma_master`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `hold`, `ads`, `blast` and `dstb` are low, and `addr_o` and `left_o` are zero.
- R2: A request does not raise `hold` until both the address and the count have been written and the remaining count is nonzero. Once the count reaches zero, a persisting request is ignored.
- R3: With `dir` = 1, the request is `fifo_empty` low. With `dir` = 0, the request is `fifo_full` low. The flag that is not selected has no effect.
- R4: `hold` rises on the cycle after an accepted request. No address or data phase starts until `hlda` has been sampled high.
- R5: The address phase (`ads` high) lasts exactly one cycle. A data phase (`dstb` high) completes only on a cycle with `rdy_n` low, and a cycle with `rdy_n` high stretches it. Each completed phase adds 4 to `addr_o` and subtracts 4 from `left_o`, which holds bytes.
- R6: A burst has at most 4 completed data phases. A longer transfer continues with a new address phase that carries the advanced address.
- R7: `blast` is high exactly on the final data phase of a burst. A burst that has only one word left goes straight from the address phase to that final phase.
- R8: If `stop` is high while a non-final data phase completes, the next data phase becomes the final one, with `blast` high.
- R9: `stop` is ignored during the final data phase. That phase still waits for ready and then enters recovery.
- R10: In recovery, the engine stays in place as long as `rdy_n` is low. It starts no address phase and keeps `hold` high.
- R11: In recovery with `rdy_n` high, a zero count or a high `stop` returns the engine to idle with `hold` low. The remaining count is kept, so the transfer can resume later.
- R12: In recovery with `rdy_n` high, the count nonzero and `stop` low, the engine starts a new address phase if the request is still present. If the request has gone, it releases the bus.
- R13: Writes to the address or the count are ignored while `hold` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_addr_we | input | 1 | Load start address from `cfg_wdata` |
| cfg_cnt_we | input | 1 | Load byte count from `cfg_wdata[CNT_W-1:0]` |
| cfg_wdata | input | ADDR_W | Programming data |
| dir | input | 1 | 1: drain empty-flag FIFO to the bus; 0: fill full-flag FIFO from the bus |
| fifo_empty | input | 1 | Outbound FIFO empty flag |
| fifo_full | input | 1 | Inbound FIFO full flag |
| stop | input | 1 | Stop condition from the FIFO side |
| hlda | input | 1 | Hold acknowledge from the bus owner |
| rdy_n | input | 1 | Target ready, active low |
| hold | output | 1 | Bus hold request |
| ads | output | 1 | Address phase strobe |
| blast | output | 1 | Final data phase of the burst |
| dstb | output | 1 | Data phase strobe |
| addr_o | output | ADDR_W | Current bus address |
| left_o | output | CNT_W | Remaining byte count |

## Verification
The case that matters most is a stop arriving in the same cycle that ready completes a non-final data phase. In that cycle the engine must both advance the address and count and redirect the next phase to be the final one. The bench provokes this by raising `stop` exactly on the second beat of a four-beat-capable burst, with zero wait states. It judges the result from the logged burst lengths (3, then 4, then 1) and from `blast` in the cycle that follows. A second pairing places `stop` on the final phase itself and expects it to have no effect there. A third case has ready wait states in the same run as a count write that is illegal while busy. It checks that the address step and the remaining count stay intact.

// File: rtl/bdm_pkg.sv
package bdm_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_HREQ  = 3'd1,
      ST_ADDR  = 3'd2,
      ST_DATA  = 3'd3,
      ST_LAST  = 3'd4,
      ST_RECOV = 3'd5
   } bdm_state_t;
endpackage

// File: rtl/bdm_req_sel.sv
module bdm_req_sel #(
   parameter int SYNC_REQ = 0
) (
   input  logic clk,
   input  logic rst,
   input  logic dir,
   input  logic fifo_empty,
   input  logic fifo_full,
   output logic req
);
   logic raw_req;

   // direction 1: data waiting to go out; direction 0: room to fill
   assign raw_req = dir ? ~fifo_empty : ~fifo_full;

   initial begin
      assert (SYNC_REQ == 0 || SYNC_REQ == 1)
         else $error("bdm_req_sel: SYNC_REQ must be 0 or 1");
   end

   generate
      if (SYNC_REQ != 0) begin : g_reg
         logic req_q;
         always_ff @(posedge clk) begin
            if (rst) req_q <= 1'b0;
            else     req_q <= raw_req;
         end
         assign req = req_q;
      end else begin : g_comb
         logic unused_clk_rst;
         assign unused_clk_rst = clk ^ rst;
         assign req = raw_req;
      end
   endgenerate
endmodule

// File: rtl/bdm_regs.sv
module bdm_regs #(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 16,
   parameter int BYTES  = 4,
   localparam int OFS    = $clog2(BYTES),
   localparam int WCNT_W = CNT_W - OFS
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_en,
   input  logic              cfg_addr_we,
   input  logic              cfg_cnt_we,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic              beat_done,
   output logic [ADDR_W-1:0] addr,
   output logic [WCNT_W-1:0] words,
   output logic [CNT_W-1:0]  left_bytes,
   output logic              armed
);
   logic addr_ok, cnt_ok;

   initial begin
      assert (BYTES >= 1 && (1 << OFS) == BYTES)
         else $error("bdm_regs: BYTES must be a power of two");
      assert (CNT_W <= ADDR_W && WCNT_W >= 3)
         else $error("bdm_regs: count width out of range");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         addr    <= '0;
         addr_ok <= 1'b0;
      end else if (cfg_en && cfg_addr_we) begin
         addr    <= cfg_wdata;
         addr_ok <= 1'b1;
      end else if (beat_done) begin
         addr    <= addr + ADDR_W'(BYTES);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         words  <= '0;
         cnt_ok <= 1'b0;
      end else if (cfg_en && cfg_cnt_we) begin
         words  <= cfg_wdata[CNT_W-1:OFS];
         cnt_ok <= 1'b1;
      end else if (beat_done) begin
         words  <= words - WCNT_W'(1);
      end
   end

   assign armed = addr_ok & cnt_ok & (words != '0);

   generate
      if (OFS == 0) begin : g_bytewide
         assign left_bytes = words;
      end else begin : g_wordwide
         assign left_bytes = {words, {OFS{1'b0}}};
      end
   endgenerate

   // R5
   addr_step_chk: assert property (@(posedge clk) disable iff (rst)
      beat_done |=> addr == $past(addr) + ADDR_W'(BYTES));
   // R5
   cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
      beat_done |=> words == $past(words) - WCNT_W'(1));
   // R13
   cfg_lock_chk: assert property (@(posedge clk) disable iff (rst)
      (!cfg_en && !beat_done) |=> ($stable(words) && $stable(addr)));
   // R11
   no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
      beat_done |-> words != '0);
endmodule

// File: rtl/bdm_fsm.sv
module bdm_fsm
   import bdm_pkg::*;
#(
   parameter int WCNT_W    = 14,
   parameter int MAX_BEATS = 4,
   localparam int BW = (MAX_BEATS > 2) ? $clog2(MAX_BEATS) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req,
   input  logic              armed,
   input  logic [WCNT_W-1:0] words,
   input  logic              stop,
   input  logic              hlda,
   input  logic              rdy_n,
   output logic              hold,
   output logic              ads,
   output logic              blast,
   output logic              dstb,
   output logic              beat_done,
   output logic              idle
);
   bdm_state_t      st, st_n;
   logic [BW-1:0]   beat, beat_n;
   logic            end_burst;

   initial begin
      assert (MAX_BEATS >= 2 && MAX_BEATS <= (1 << BW))
         else $error("bdm_fsm: MAX_BEATS out of range");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st   <= ST_IDLE;
         beat <= '0;
      end else begin
         st   <= st_n;
         beat <= beat_n;
      end
   end

   // a completing non-final beat leaves one beat for the final phase
   assign end_burst = stop || (words == WCNT_W'(2)) ||
                      (beat == BW'(MAX_BEATS - 2));

   always_comb begin
      st_n   = st;
      beat_n = beat;
      unique case (st)
         ST_IDLE:  if (req && armed) st_n = ST_HREQ;
         ST_HREQ: begin
            if (!req)      st_n = ST_IDLE;
            else if (hlda) st_n = ST_ADDR;
         end
         ST_ADDR: begin
            beat_n = '0;
            st_n   = (words == WCNT_W'(1)) ? ST_LAST : ST_DATA;
         end
         ST_DATA: begin
            if (!rdy_n) begin
               if (end_burst) st_n = ST_LAST;
               else           beat_n = beat + BW'(1);
            end
         end
         ST_LAST:  if (!rdy_n) st_n = ST_RECOV;
         ST_RECOV: begin
            if (rdy_n)
               st_n = (req && words != '0 && !stop) ? ST_ADDR : ST_IDLE;
         end
         default:  st_n = ST_IDLE;
      endcase
   end

   assign hold      = (st != ST_IDLE);
   assign idle      = (st == ST_IDLE);
   assign ads       = (st == ST_ADDR);
   assign blast     = (st == ST_LAST);
   assign dstb      = (st == ST_DATA) || (st == ST_LAST);
   assign beat_done = dstb && !rdy_n;

   logic [BW:0] chk_beats;
   always_ff @(posedge clk) begin
      if (rst || ads)     chk_beats <= '0;
      else if (beat_done) chk_beats <= chk_beats + (BW+1)'(1);
   end

   // R6
   burst_cap_chk: assert property (@(posedge clk) disable iff (rst)
      beat_done |-> chk_beats < (BW+1)'(MAX_BEATS));
   // R4
   hold_cause_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(hold) |-> $past(req));
   // R5
   addr_once_chk: assert property (@(posedge clk) disable iff (rst)
      ads |=> (dstb && !ads));
   // R7
   blast_in_data_chk: assert property (@(posedge clk) disable iff (rst)
      blast |-> dstb);
   // R9
   last_to_recov_chk: assert property (@(posedge clk) disable iff (rst)
      (blast && !rdy_n) |=> (hold && !dstb && !ads));
   // R10
   recov_wait_chk: assert property (@(posedge clk) disable iff (rst)
      (st == ST_RECOV && !rdy_n) |=> st == ST_RECOV);
   // R11
   stop_release_chk: assert property (@(posedge clk) disable iff (rst)
      (st == ST_RECOV && rdy_n && stop) |=> !hold);
endmodule

// File: rtl/burst_dma_master.sv
module burst_dma_master #(
   parameter int ADDR_W    = 32,
   parameter int CNT_W     = 16,
   parameter int BYTES     = 4,
   parameter int MAX_BEATS = 4,
   parameter int SYNC_REQ  = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_addr_we,
   input  logic              cfg_cnt_we,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic              dir,
   input  logic              fifo_empty,
   input  logic              fifo_full,
   input  logic              stop,
   input  logic              hlda,
   input  logic              rdy_n,
   output logic              hold,
   output logic              ads,
   output logic              blast,
   output logic              dstb,
   output logic [ADDR_W-1:0] addr_o,
   output logic [CNT_W-1:0]  left_o
);
   localparam int WCNT_W = CNT_W - $clog2(BYTES);

   logic              req, armed, beat_done, idle;
   logic [WCNT_W-1:0] words;

   bdm_req_sel #(.SYNC_REQ(SYNC_REQ)) u_req (
      .clk        (clk),
      .rst        (rst),
      .dir        (dir),
      .fifo_empty (fifo_empty),
      .fifo_full  (fifo_full),
      .req        (req)
   );

   bdm_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BYTES(BYTES)) u_regs (
      .clk         (clk),
      .rst         (rst),
      .cfg_en      (idle),
      .cfg_addr_we (cfg_addr_we),
      .cfg_cnt_we  (cfg_cnt_we),
      .cfg_wdata   (cfg_wdata),
      .beat_done   (beat_done),
      .addr        (addr_o),
      .words       (words),
      .left_bytes  (left_o),
      .armed       (armed)
   );

   bdm_fsm #(.WCNT_W(WCNT_W), .MAX_BEATS(MAX_BEATS)) u_fsm (
      .clk       (clk),
      .rst       (rst),
      .req       (req),
      .armed     (armed),
      .words     (words),
      .stop      (stop),
      .hlda      (hlda),
      .rdy_n     (rdy_n),
      .hold      (hold),
      .ads       (ads),
      .blast     (blast),
      .dstb      (dstb),
      .beat_done (beat_done),
      .idle      (idle)
   );
endmodule

// File: tb/sim_burst_dma_master.sv
module sim_burst_dma_master;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cfg_addr_we = 1'b0, cfg_cnt_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic        dir = 1'b1, fifo_empty = 1'b1, fifo_full = 1'b1, stop = 1'b0;
   logic        hlda = 1'b0;
   logic        rdy_n;
   logic        hold, ads, blast, dstb;
   logic [31:0] addr_o;
   logic [15:0] left_o;

   logic grant_en = 1'b1, force_low = 1'b0, ws_en = 1'b0, ws_ph = 1'b0;

   int n_cmp = 0, n_mis = 0;
   int bl_log [16];
   logic [31:0] ads_log [16];
   int n_bl = 0, n_ads = 0, cur_beats = 0, n_dcyc = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   burst_dma_master u0 (
      .clk(clk), .rst(rst), .cfg_addr_we(cfg_addr_we), .cfg_cnt_we(cfg_cnt_we),
      .cfg_wdata(cfg_wdata), .dir(dir), .fifo_empty(fifo_empty),
      .fifo_full(fifo_full), .stop(stop), .hlda(hlda), .rdy_n(rdy_n),
      .hold(hold), .ads(ads), .blast(blast), .dstb(dstb),
      .addr_o(addr_o), .left_o(left_o)
   );

   // bus model: grant follows hold by one cycle; target optionally inserts a wait
   assign rdy_n = force_low ? 1'b0 : ~(dstb & (ws_en ? ws_ph : 1'b1));
   always @(posedge clk) begin
      hlda  <= hold & grant_en;
      ws_ph <= rst ? 1'b0 : (dstb ? ~ws_ph : 1'b0);
   end

   always @(negedge clk) begin
      if (!rst) begin
         if (ads && n_ads < 16) begin ads_log[n_ads] = addr_o; n_ads++; end
         if (dstb) n_dcyc++;
         if (dstb && !rdy_n) begin
            cur_beats++;
            if (blast) begin
               if (n_bl < 16) begin bl_log[n_bl] = cur_beats; n_bl++; end
               cur_beats = 0;
            end
         end
      end
   end

   task automatic chk(input string tag, input longint act, input longint exp);
      n_cmp++;
      if (act != exp) begin
         n_mis++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic clear_logs();
      n_bl = 0; n_ads = 0; cur_beats = 0; n_dcyc = 0;
   endtask

   task automatic prog(input logic [31:0] a, input logic [31:0] bytes);
      @(negedge clk); cfg_addr_we = 1'b1; cfg_wdata = a;
      @(negedge clk); cfg_addr_we = 1'b0; cfg_cnt_we = 1'b1; cfg_wdata = bytes;
      @(negedge clk); cfg_cnt_we = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 50 && !hold; i++) @(negedge clk);
      for (int i = 0; i < 3000 && hold; i++) @(negedge clk);
   endtask

   task automatic wait_sig(input int which);
      for (int i = 0; i < 500; i++) begin
         @(negedge clk);
         if (which == 0 && ads) break;
         if (which == 1 && blast) break;
      end
   endtask

   task automatic t_reset();
      chk("R1 hold", hold, 0); chk("R1 ads", ads, 0); chk("R1 blast", blast, 0);
      chk("R1 dstb", dstb, 0); chk("R1 addr", addr_o, 0); chk("R1 left", left_o, 0);
   endtask

   task automatic t_unarmed();
      fifo_empty = 1'b0;
      repeat (4) @(negedge clk);
      chk("R2 no program", hold, 0);
      @(negedge clk); cfg_addr_we = 1'b1; cfg_wdata = 32'h40;
      @(negedge clk); cfg_addr_we = 1'b0;
      repeat (4) @(negedge clk);
      chk("R2 addr only", hold, 0);
      @(negedge clk); cfg_cnt_we = 1'b1; cfg_wdata = 32'h0;
      @(negedge clk); cfg_cnt_we = 1'b0;
      repeat (4) @(negedge clk);
      chk("R2 zero count", hold, 0);
      fifo_empty = 1'b1;
   endtask

   task automatic t_main();
      prog(32'h100, 24); clear_logs();
      fifo_empty = 1'b0;
      @(negedge clk); chk("R4 hold next cycle", hold, 1);
      wait_idle();
      chk("R6 burst count", n_bl, 2);
      chk("R6 first burst", bl_log[0], 4);
      chk("R7 second burst", bl_log[1], 2);
      chk("R6 first addr", ads_log[0], 32'h100);
      chk("R6 second addr", ads_log[1], 32'h110);
      chk("R5 end addr", addr_o, 32'h118);
      chk("R11 left zero", left_o, 0);
      repeat (3) @(negedge clk);
      chk("R2 done ignores req", hold, 0);
      fifo_empty = 1'b1;
   endtask

   task automatic t_hlda();
      prog(32'h900, 16); clear_logs();
      grant_en = 1'b0; fifo_empty = 1'b0;
      @(negedge clk); chk("R4 hold raised", hold, 1);
      repeat (5) begin
         @(negedge clk);
         chk("R4 no phase before hlda", {ads, dstb}, 0);
      end
      grant_en = 1'b1;
      wait_idle();
      chk("R4 burst after grant", bl_log[0], 4);
      chk("R4 end addr", addr_o, 32'h910);
      fifo_empty = 1'b1;
   endtask

   task automatic t_dir();
      prog(32'h200, 12); clear_logs();
      dir = 1'b0; fifo_empty = 1'b0; fifo_full = 1'b1;
      repeat (4) @(negedge clk);
      chk("R3 empty flag ignored when dir=0", hold, 0);
      fifo_full = 1'b0;
      wait_idle();
      chk("R3 fill burst", bl_log[0], 3);
      chk("R3 fill end addr", addr_o, 32'h20C);
      fifo_full = 1'b1; fifo_empty = 1'b1; dir = 1'b1;
   endtask

   task automatic t_single();
      prog(32'h300, 4); clear_logs();
      fifo_empty = 1'b0;
      wait_idle();
      chk("R7 single burst count", n_bl, 1);
      chk("R7 single beat with blast", bl_log[0], 1);
      chk("R7 single addr", ads_log[0], 32'h300);
      chk("R7 data cycles", n_dcyc, 1);
      fifo_empty = 1'b1;
   endtask

   task automatic t_stop_data();
      prog(32'h400, 32); clear_logs();
      fifo_empty = 1'b0;
      wait_sig(0);
      @(negedge clk);
      @(negedge clk); stop = 1'b1;
      @(negedge clk); chk("R8 blast after stop", blast, 1);
      @(negedge clk); chk("R9 last phase finished", {hold, dstb}, 2'b10);
      stop = 1'b0;
      wait_idle();
      chk("R8 burst count", n_bl, 3);
      chk("R8 cut burst", bl_log[0], 3);
      chk("R9 next burst", bl_log[1], 4);
      chk("R8 tail burst", bl_log[2], 1);
      chk("R8 end addr", addr_o, 32'h420);
      fifo_empty = 1'b1;
   endtask

   task automatic t_stop_recov();
      prog(32'h500, 32); clear_logs();
      fifo_empty = 1'b0;
      wait_sig(1); stop = 1'b1;
      @(negedge clk); chk("R9 recovery held", hold, 1);
      @(negedge clk); chk("R11 stop releases", hold, 0);
      chk("R11 count kept", left_o, 16);
      stop = 1'b0;
      wait_idle();
      chk("R11 resumed end addr", addr_o, 32'h520);
      chk("R11 resumed bursts", n_bl, 2);
      fifo_empty = 1'b1;
   endtask

   task automatic t_req_gone();
      prog(32'h600, 32); clear_logs();
      fifo_empty = 1'b0;
      wait_sig(1); fifo_empty = 1'b1;
      @(negedge clk);
      @(negedge clk); chk("R12 release on lost req", hold, 0);
      chk("R12 count kept", left_o, 16);
      fifo_empty = 1'b0;
      wait_idle();
      chk("R12 resumed end addr", addr_o, 32'h620);
      fifo_empty = 1'b1;
   endtask

   task automatic t_recov_wait();
      prog(32'h700, 32); clear_logs();
      fifo_empty = 1'b0;
      wait_sig(1); force_low = 1'b1;
      repeat (3) begin
         @(negedge clk);
         chk("R10 waits in recovery", {hold, ads, dstb}, 3'b100);
      end
      force_low = 1'b0;
      @(negedge clk);
      chk("R12 new address phase", ads, 1);
      chk("R12 continued address", addr_o, 32'h710);
      wait_idle();
      fifo_empty = 1'b1;
   endtask

   task automatic t_waits_cfg();
      prog(32'h800, 20); clear_logs();
      ws_en = 1'b1; fifo_empty = 1'b0;
      wait_sig(0);
      cfg_cnt_we = 1'b1; cfg_wdata = 32'h4;
      @(negedge clk); cfg_cnt_we = 1'b0; cfg_addr_we = 1'b1; cfg_wdata = 32'h0;
      @(negedge clk); cfg_addr_we = 1'b0;
      wait_idle();
      chk("R13 count write ignored", n_bl, 2);
      chk("R13 first burst", bl_log[0], 4);
      chk("R13 addr write ignored", addr_o, 32'h814);
      chk("R5 wait states double data cycles", n_dcyc, 10);
      chk("R5 left zero", left_o, 0);
      ws_en = 1'b0; fifo_empty = 1'b1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_unarmed();
      t_main();
      t_hlda();
      t_dir();
      t_single();
      t_stop_data();
      t_stop_recov();
      t_req_gone();
      t_recov_wait();
      t_waits_cfg();
      repeat (3) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++; n_mis++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
   end
endmodule